// File: doc/BRIEF.md
# Boot-Memory Cycle Width and Speed Sequencer

This block runs memory read and write cycles for two boot-memory regions, a primary ROM select and a secondary DOS select. Both regions share one bus with the other bus devices: the same address, data, read and write strobes, and 16-bit acknowledge. The CPU side gives it one request at a time: a word address, read or write, two byte enables, write data and which region to use. The block then drives the chip select, the address with the byte lane in bit 0, the byte-high enable and the command strobe. It returns a one-cycle done pulse with the read data and a flag that tells whether the bus ran 16 bits wide.

Each region has its own speed bit. A slow access follows a bus-clock enable pulse that the system supplies. A fast access runs at CPU clock rate. The width of an access is chosen once, when the setup phase ends. The DOS region can be forced wide by a configuration bit. Otherwise width comes from the sampled memory or I/O 16-bit acknowledge. Fast ROM accesses never trust that acknowledge. For a programmable number of clocks after any 16-bit bus cycle, the acknowledge is ignored, because a device that ran the earlier cycle may still be holding it. When a two-byte request lands on an 8-bit cycle, the block runs two byte cycles, low byte first, and merges the bytes into one result.

Top module: `romBusSizer`

## Requirements
- R1: `reqReady` is 1 only while no access is in progress. Each accepted request (`reqValid` high while `reqReady` is 1 at a clock edge) produces exactly one one-cycle `done` pulse, and `reqReady` stays 0 from acceptance until that pulse.
- R2: During an access, `romCs` is 1 for `reqSelDos`=0 and `dosCs` is 1 for `reqSelDos`=1. The two are never high together, and both are 0 when idle.
- R3: In fast mode, each byte or word cycle holds its command strobe for exactly `cfgFastClks` CPU clocks (values 1 and up).
- R4: In slow mode, the strobe rises on the first `busClkEn` pulse after setup begins and falls on the third pulse after that. The strobe is therefore high for exactly three bus-clock periods.
- R5: `memRd` strobes reads and `memWr` strobes writes. They are never high together.
- R6: The cycle is 16-bit (`doneWide`=1, a single strobe) when `memAck16` or `ioAck16` is 1 at the end of setup and is not masked.
- R7: A fast ROM-select cycle is always 8-bit, whatever the acknowledges do.
- R8: With `cfgDosForce16`=1, every DOS-select access is 16-bit without any acknowledge. The bit has no effect on ROM-select accesses.
- R9: The end of any 16-bit cycle (this block's own, or `extBus16End` from another bus master) masks both acknowledges for the next `cfgMaskClks` clocks.
- R10: A request with both byte enables that ends up 8-bit runs two byte cycles, with `busAddr[0]`=0 first and 1 second. `rdata` returns low byte then high byte as one word with `doneWide`=0.
- R11: `sbhe` equals `reqBe[1]` for the whole access. The first cycle's `busAddr[0]` is the inverse of `reqBe[0]`. An 8-bit write puts the addressed byte on `busWdata[7:0]`. An 8-bit read takes its byte from `busRdata[7:0]` into the lane that `busAddr[0]` selects.
- R12: After reset, `reqReady` is 1 and all selects, strobes, `done` and `doneWide` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle, request may be taken |
| reqSelDos | input | 1 | 0 = ROM select, 1 = DOS select |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBe | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| reqWordAddr | input | AW-1 | Word address |
| reqWdata | input | 16 | Write data |
| cfgRomFast | input | 1 | ROM select uses CPU-clock timing |
| cfgDosFast | input | 1 | DOS select uses CPU-clock timing |
| cfgDosForce16 | input | 1 | Force DOS select accesses to 16-bit |
| cfgFastClks | input | CW | Strobe length of a fast cycle in CPU clocks |
| cfgMaskClks | input | MW | Acknowledge mask window in CPU clocks |
| busClkEn | input | 1 | One-clock pulse per bus clock period |
| memAck16 | input | 1 | Memory 16-bit acknowledge |
| ioAck16 | input | 1 | I/O 16-bit acknowledge |
| extBus16End | input | 1 | Pulse: another master's 16-bit cycle ended |
| romCs | output | 1 | ROM chip select |
| dosCs | output | 1 | DOS chip select |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| sbhe | output | 1 | Byte-high enable |
| busAddr | output | AW | Bus byte address |
| busWdata | output | 16 | Bus write data |
| busRdata | input | 16 | Bus read data |
| done | output | 1 | Access complete pulse |
| doneWide | output | 1 | With done: access ran 16-bit |
| rdata | output | 16 | Read result, valid with done |

## Verification
The bench holds an acknowledge high across fast ROM accesses. A design that trusted it there would report a wide cycle and a single strobe. The bench also starts an access in the very next clock after a forced 16-bit DOS cycle, and again together with an external 16-bit end pulse. A missing or short mask would widen those accesses, while a mask that never expires would make the later, clean acknowledge test come out narrow. Split word reads are checked for byte order and merged data, so a swapped or missing second cycle shows up as a wrong word or a wrong strobe count. Slow strobes are counted against the bus-clock pulse spacing, and an off-by-one pulse count changes the total by four clocks.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch a new request
    logic active;   // access in progress
    logic phaseHi;  // second byte cycle of a split word
    logic capture;  // last strobe clock, take read data
    logic wide;     // current cycle is 16-bit
  } dpCtlT;
endpackage

// File: rtl/rbsCtrl.sv
module rbsCtrl
  import rbs_pkg::*;
#(
  parameter int CW = 4,
  parameter int MW = 4,
  parameter int SLOW_TICKS = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqSelDos,
  input  logic          reqWrite,
  input  logic [1:0]    reqBe,
  input  logic          cfgRomFast,
  input  logic          cfgDosFast,
  input  logic          cfgDosForce16,
  input  logic [CW-1:0] cfgFastClks,
  input  logic [MW-1:0] cfgMaskClks,
  input  logic          busClkEn,
  input  logic          memAck16,
  input  logic          ioAck16,
  input  logic          extBus16End,
  output logic          reqReady,
  output logic          romCs,
  output logic          dosCs,
  output logic          memRd,
  output logic          memWr,
  output logic          done,
  output logic          doneWide,
  output dpCtlT         dpCtl
);
  localparam int CNT_W = (CW > $clog2(SLOW_TICKS + 1)) ? CW : $clog2(SLOW_TICKS + 1);

  seqStateT          state;
  logic              selDos, isWr, beWord, fastMode, phaseHi, wide;
  logic [CNT_W-1:0]  strobeCnt;
  logic [MW-1:0]     maskCnt;
  logic              doneR, doneWideR;

  logic accept, setupGo, tick, lastTick, finish, splitNext, widthPick, ackMasked;

  assign accept    = reqValid && (state == ST_IDLE);
  assign setupGo   = fastMode || busClkEn;
  assign tick      = fastMode || busClkEn;
  assign ackMasked = (maskCnt != '0);

  // width choice at end of setup
  always_comb begin
    if (selDos && cfgDosForce16)
      widthPick = 1'b1;
    else if (!selDos && fastMode)
      widthPick = 1'b0;
    else
      widthPick = (memAck16 || ioAck16) && !ackMasked;
  end

  always_comb begin
    if (fastMode)
      lastTick = ({1'b0, strobeCnt} + 1'b1) >= {{(CNT_W + 1 - CW){1'b0}}, cfgFastClks};
    else
      lastTick = (strobeCnt == CNT_W'(SLOW_TICKS - 1));
  end

  assign finish    = (state == ST_STROBE) && tick && lastTick;
  assign splitNext = !wide && beWord && !phaseHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      selDos    <= 1'b0;
      isWr      <= 1'b0;
      beWord    <= 1'b0;
      fastMode  <= 1'b0;
      phaseHi   <= 1'b0;
      wide      <= 1'b0;
      strobeCnt <= '0;
      doneR     <= 1'b0;
      doneWideR <= 1'b0;
    end else begin
      doneR     <= 1'b0;
      doneWideR <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            selDos   <= reqSelDos;
            isWr     <= reqWrite;
            beWord   <= (reqBe == 2'b11);
            fastMode <= reqSelDos ? cfgDosFast : cfgRomFast;
            phaseHi  <= 1'b0;
            wide     <= 1'b0;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (setupGo) begin
            if (!phaseHi) wide <= widthPick;
            strobeCnt <= '0;
            state     <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          if (finish) begin
            if (splitNext) begin
              phaseHi <= 1'b1;
              state   <= ST_SETUP;
            end else begin
              doneR     <= 1'b1;
              doneWideR <= wide;
              state     <= ST_IDLE;
            end
          end else if (tick) begin
            strobeCnt <= strobeCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // acknowledge mask window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      maskCnt <= '0;
    else if ((finish && wide) || extBus16End)
      maskCnt <= cfgMaskClks;
    else if (maskCnt != '0)
      maskCnt <= maskCnt - 1'b1;
  end

  assign reqReady = (state == ST_IDLE);
  assign romCs    = (state != ST_IDLE) && !selDos;
  assign dosCs    = (state != ST_IDLE) && selDos;
  assign memRd    = (state == ST_STROBE) && !isWr;
  assign memWr    = (state == ST_STROBE) && isWr;
  assign done     = doneR;
  assign doneWide = doneWideR;

  assign dpCtl.load    = accept;
  assign dpCtl.active  = (state != ST_IDLE);
  assign dpCtl.phaseHi = phaseHi;
  assign dpCtl.capture = finish;
  assign dpCtl.wide    = wide;

  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(memRd && memWr));

  // R2
  cs_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(romCs && dosCs));

  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);

  // R7
  fast_rom_narrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !selDos && fastMode) |-> !doneWide);

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETUP && setupGo && !phaseHi && ackMasked && !(selDos && cfgDosForce16))
      |=> !wide);

  // R4
  slow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE && !fastMode && !busClkEn) |=> (state == ST_STROBE));
endmodule

// File: rtl/rbsData.sv
module rbsData
  import rbs_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtlT         dpCtl,
  input  logic [AW-2:0] reqWordAddr,
  input  logic [1:0]    reqBe,
  input  logic [DW-1:0] reqWdata,
  input  logic [DW-1:0] busRdata,
  output logic [AW-1:0] busAddr,
  output logic          sbhe,
  output logic [DW-1:0] busWdata,
  output logic [DW-1:0] rdata
);
  localparam int HW = DW / 2;

  logic [AW-2:0] addrR;
  logic [1:0]    beR;
  logic [DW-1:0] wdataR;
  logic [DW-1:0] rdataR;
  logic          laneHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR  <= '0;
      beR    <= '0;
      wdataR <= '0;
    end else if (dpCtl.load) begin
      addrR  <= reqWordAddr;
      beR    <= reqBe;
      wdataR <= reqWdata;
    end
  end

  assign laneHi  = dpCtl.phaseHi ? 1'b1 : !beR[0];
  assign busAddr = {addrR, laneHi};
  assign sbhe    = dpCtl.active && beR[1];

  always_comb begin
    if (dpCtl.wide)
      busWdata = wdataR;
    else
      busWdata = {wdataR[DW-1:HW], laneHi ? wdataR[DW-1:HW] : wdataR[HW-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataR <= '0;
    end else if (dpCtl.load) begin
      rdataR <= '0;
    end else if (dpCtl.capture) begin
      if (dpCtl.wide)
        rdataR <= busRdata;
      else if (laneHi)
        rdataR[DW-1:HW] <= busRdata[HW-1:0];
      else
        rdataR[HW-1:0] <= busRdata[HW-1:0];
    end
  end

  assign rdata = rdataR;

  // R11
  lane_second_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.active && dpCtl.phaseHi) |-> busAddr[0]);
endmodule

// File: rtl/romBusSizer.sv
module romBusSizer
  import rbs_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 4,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic          reqSelDos,
  input  logic          reqWrite,
  input  logic [1:0]    reqBe,
  input  logic [AW-2:0] reqWordAddr,
  input  logic [15:0]   reqWdata,
  input  logic          cfgRomFast,
  input  logic          cfgDosFast,
  input  logic          cfgDosForce16,
  input  logic [CW-1:0] cfgFastClks,
  input  logic [MW-1:0] cfgMaskClks,
  input  logic          busClkEn,
  input  logic          memAck16,
  input  logic          ioAck16,
  input  logic          extBus16End,
  output logic          romCs,
  output logic          dosCs,
  output logic          memRd,
  output logic          memWr,
  output logic          sbhe,
  output logic [AW-1:0] busAddr,
  output logic [15:0]   busWdata,
  input  logic [15:0]   busRdata,
  output logic          done,
  output logic          doneWide,
  output logic [15:0]   rdata
);
  dpCtlT dpCtl;

  rbsCtrl #(.CW(CW), .MW(MW), .SLOW_TICKS(3)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSelDos(reqSelDos),
    .reqWrite(reqWrite), .reqBe(reqBe), .cfgRomFast(cfgRomFast),
    .cfgDosFast(cfgDosFast), .cfgDosForce16(cfgDosForce16),
    .cfgFastClks(cfgFastClks), .cfgMaskClks(cfgMaskClks), .busClkEn(busClkEn),
    .memAck16(memAck16), .ioAck16(ioAck16), .extBus16End(extBus16End),
    .reqReady(reqReady), .romCs(romCs), .dosCs(dosCs), .memRd(memRd),
    .memWr(memWr), .done(done), .doneWide(doneWide), .dpCtl(dpCtl)
  );

  rbsData #(.AW(AW), .DW(16)) uData (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .reqWordAddr(reqWordAddr),
    .reqBe(reqBe), .reqWdata(reqWdata), .busRdata(busRdata),
    .busAddr(busAddr), .sbhe(sbhe), .busWdata(busWdata), .rdata(rdata)
  );
endmodule

// File: tb/sim_romBusSizer.sv
module sim_romBusSizer;
  localparam int AW = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqSelDos = 0, reqWrite = 0;
  logic [1:0] reqBe = 2'b01;
  logic [AW-2:0] reqWordAddr = '0;
  logic [15:0] reqWdata = '0;
  logic cfgRomFast = 1, cfgDosFast = 1, cfgDosForce16 = 0;
  logic [3:0] cfgFastClks = 4'd2;
  logic [3:0] cfgMaskClks = 4'd2;
  logic busClkEn = 0, memAck16 = 0, ioAck16 = 0, extBus16End = 0;
  logic reqReady, romCs, dosCs, memRd, memWr, sbhe, done, doneWide;
  logic [AW-1:0] busAddr;
  logic [15:0] busWdata, busRdata, rdata;

  int checks = 0, fails = 0;
  logic [1:0] divCnt = 0;

  always #2.5 clk = ~clk;

  // bus clock enable: one clock in four
  always @(negedge clk) begin
    divCnt   = divCnt + 1'b1;
    busClkEn = (divCnt == 2'd3);
  end

  // target model: addressed byte on the low lane for 8-bit, full word for 16-bit
  assign busRdata = busAddr[0] ? 16'hB7B7 : 16'hB74E;

  romBusSizer #(.AW(AW), .CW(4), .MW(4)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqSelDos(reqSelDos), .reqWrite(reqWrite), .reqBe(reqBe),
    .reqWordAddr(reqWordAddr), .reqWdata(reqWdata), .cfgRomFast(cfgRomFast),
    .cfgDosFast(cfgDosFast), .cfgDosForce16(cfgDosForce16),
    .cfgFastClks(cfgFastClks), .cfgMaskClks(cfgMaskClks), .busClkEn(busClkEn),
    .memAck16(memAck16), .ioAck16(ioAck16), .extBus16End(extBus16End),
    .romCs(romCs), .dosCs(dosCs), .memRd(memRd), .memWr(memWr), .sbhe(sbhe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .done(done),
    .doneWide(doneWide), .rdata(rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // results of the last access
  int strobeCycles, phases, readyLeak, csWrong, bothStrobe, sbheWrong;
  logic [1:0] addr0Seq;
  logic [7:0] lowLane0;
  logic gotWide;
  logic [15:0] gotData;

  // one access; called while sitting just after a falling edge
  task automatic doAccess(input logic dos, input logic wr, input logic [1:0] be,
                          input logic [15:0] wd);
    logic prevStrobe;
    int guard;
    strobeCycles = 0; phases = 0; readyLeak = 0; csWrong = 0; bothStrobe = 0;
    sbheWrong = 0; addr0Seq = 2'b00; lowLane0 = 8'h00; prevStrobe = 0; guard = 0;
    while (!reqReady) @(negedge clk);
    reqSelDos = dos; reqWrite = wr; reqBe = be; reqWdata = wd;
    reqWordAddr = 23'h01234;
    reqValid = 1;
    @(posedge clk);
    #1 reqValid = 0;
    extBus16End = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (done || guard > 300) break;
      if (reqReady) readyLeak++;
      if (romCs !== !dos || dosCs !== dos) csWrong++;
      if (memRd && memWr) bothStrobe++;
      if (sbhe !== be[1]) sbheWrong++;
      if (memRd || memWr) begin
        strobeCycles++;
        if (!prevStrobe) begin
          if (phases < 2) addr0Seq[phases] = busAddr[0];
          if (phases == 0) lowLane0 = busWdata[7:0];
          phases++;
        end
        if ((memRd !== !wr) || (memWr !== wr)) bothStrobe++;
      end
      prevStrobe = memRd || memWr;
    end
    check("R1 done reached", 32'(done), 32'd1);
    check("R1 ready low while busy", 32'(readyLeak), 32'd0);
    check("R2 select", 32'(csWrong), 32'd0);
    check("R5 strobe kind", 32'(bothStrobe), 32'd0);
    check("R11 sbhe level", 32'(sbheWrong), 32'd0);
    gotWide = doneWide;
    gotData = rdata;
  endtask

  task automatic tReset();
    check("R12 ready", 32'(reqReady), 32'd1);
    check("R12 selects", {30'd0, romCs, dosCs}, 32'd0);
    check("R12 strobes", {30'd0, memRd, memWr}, 32'd0);
    check("R12 done", {30'd0, done, doneWide}, 32'd0);
  endtask

  task automatic tFastRomRead();
    cfgRomFast = 1; cfgFastClks = 4'd2;
    doAccess(0, 0, 2'b01, 16'h0);
    check("R3 fast strobe length 2", 32'(strobeCycles), 32'd2);
    check("R11 low byte read", 32'(gotData), 32'h004E);
    check("R11 first lane", 32'(addr0Seq[0]), 32'd0);
    check("R6 narrow default", 32'(gotWide), 32'd0);
  endtask

  task automatic tFastRomWrite();
    cfgFastClks = 4'd4;
    doAccess(0, 1, 2'b10, 16'hA55A);
    check("R3 fast strobe length 4", 32'(strobeCycles), 32'd4);
    check("R11 odd lane address", 32'(addr0Seq[0]), 32'd1);
    check("R11 write byte on low lane", 32'(lowLane0), 32'hA5);
    cfgFastClks = 4'd2;
  endtask

  task automatic tSlowAck();
    cfgRomFast = 0; memAck16 = 1;
    repeat (6) @(negedge clk);
    doAccess(0, 0, 2'b11, 16'h0);
    check("R4 slow strobe three bus periods", 32'(strobeCycles), 32'd12);
    check("R6 mem ack widens", 32'(gotWide), 32'd1);
    check("R6 single cycle", 32'(phases), 32'd1);
    check("R6 wide read data", 32'(gotData), 32'hB74E);
    memAck16 = 0; ioAck16 = 1;
    repeat (6) @(negedge clk);
    doAccess(0, 0, 2'b11, 16'h0);
    check("R6 io ack widens", 32'(gotWide), 32'd1);
    ioAck16 = 0; cfgRomFast = 1;
  endtask

  task automatic tFastRomIgnoresAck();
    memAck16 = 1; ioAck16 = 1;
    repeat (6) @(negedge clk);
    doAccess(0, 0, 2'b11, 16'h0);
    check("R7 fast rom stays narrow", 32'(gotWide), 32'd0);
    check("R10 two byte cycles", 32'(phases), 32'd2);
    check("R10 low byte first", 32'(addr0Seq), 32'b10);
    check("R10 merged word", 32'(gotData), 32'hB74E);
    check("R10 strobe total", 32'(strobeCycles), 32'd4);
    memAck16 = 0; ioAck16 = 0;
  endtask

  task automatic tForce();
    cfgDosForce16 = 1; cfgDosFast = 1;
    repeat (6) @(negedge clk);
    doAccess(1, 0, 2'b11, 16'h0);
    check("R8 dos forced wide", 32'(gotWide), 32'd1);
    check("R8 forced single strobe", 32'(strobeCycles), 32'd2);
    // immediately after a 16-bit cycle, a stale ack must not widen
    cfgDosForce16 = 0; memAck16 = 1;
    doAccess(1, 0, 2'b11, 16'h0);
    check("R9 stale ack after own wide cycle", 32'(gotWide), 32'd0);
    memAck16 = 0;
    cfgDosForce16 = 1; cfgRomFast = 0;
    repeat (6) @(negedge clk);
    doAccess(0, 0, 2'b11, 16'h0);
    check("R8 force ignored for rom", 32'(gotWide), 32'd0);
    cfgDosForce16 = 0; cfgRomFast = 1;
  endtask

  task automatic tExtMask();
    memAck16 = 1;
    repeat (6) @(negedge clk);
    extBus16End = 1;
    doAccess(1, 0, 2'b11, 16'h0);
    check("R9 ack masked after external wide end", 32'(gotWide), 32'd0);
    repeat (6) @(negedge clk);
    doAccess(1, 0, 2'b11, 16'h0);
    check("R9 ack honoured after mask window", 32'(gotWide), 32'd1);
    memAck16 = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1;
    @(negedge clk);
    tReset();
    tFastRomRead();
    tFastRomWrite();
    tSlowAck();
    tFastRomIgnoresAck();
    tForce();
    tExtMask();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule